// File: doc/BRIEF.md
# Timeslot Radio Command Sequencer

This block times the radio commands for one 10 ms timeslot. A start-of-slot strobe begins the slot, and the role sampled at that strobe (transmit, receive or idle) selects the sequence. A microsecond tick advances two tick counters. One counts from the start of the slot. The other restarts at the end of the data frame, so the acknowledgement timing is measured from that end and not from the start of the slot.

A transmitting node fires its transmit command at a fixed offset into the slot. When its frame ends, it turns its receiver on shortly before the acknowledgement is due. It then listens until a deadline. A receiving node turns its receiver on earlier than the transmit offset and waits a bounded window for a frame to begin. After that frame ends, it issues the acknowledgement transmit command after a fixed turnaround. Commands are single-cycle strobes. Outcomes are held as flags until the next start-of-slot strobe. If a frame never ends before the slot runs out, the block stops issuing commands for that slot.

Top module: `slot_event_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, all five command strobes and all four flags are low.
- R2: In receive role (role 2'b10), `rx_on_o` pulses for one cycle right after the clock edge that samples the RX_ON_US-th tick following the start-of-slot strobe. Ticks sampled on the edge of the strobe itself are not counted.
- R3: In transmit role (role 2'b01), `tx_start_o` pulses for one cycle right after the edge that samples the TX_GO_US-th tick of the slot.
- R4: In receive role, `frame_detect_i` seen after `rx_on_o` and before the (RX_ON_US+RX_WAIT_US)-th tick opens the frame. If no such detect occurs, `rx_giveup_o` pulses after that tick and `no_frame_o` rises and holds. A detect before `rx_on_o` is ignored.
- R5: In receive role, once a frame has opened, `frame_end_i` restarts the turnaround count. `ack_tx_start_o` pulses after the ACK_TURN_US-th tick following that end. A tick on the same edge as the end is not counted.
- R6: In transmit role, `frame_end_i` after `tx_start_o` restarts the turnaround count. `ack_rx_on_o` pulses after the ACK_LISTEN_US-th tick following it.
- R7: In transmit role, `frame_detect_i` after `ack_rx_on_o` and before the ACK_LIMIT_US-th tick after the frame end sets `ack_ok_o`. Otherwise `ack_missing_o` rises after that tick. A detect before `ack_rx_on_o` is ignored. The two flags are never high together.
- R8: In idle role (2'b00, with 2'b11 treated the same), no strobe fires and no flag rises for the whole slot, whatever the radio inputs do.
- R9: If a sequence is still waiting on a frame or an acknowledgement step when the SLOT_US-th tick arrives, `overrun_o` rises and nothing more is issued. Each start-of-slot strobe clears all flags and restarts the sequence.
- R10: At most one command strobe is high in any cycle, and no strobe stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| slot_start | input | 1 | Start-of-slot strobe |
| role_i | input | 2 | Role for this slot: 00 idle, 01 transmit, 10 receive, 11 idle |
| frame_detect_i | input | 1 | Radio reports a frame beginning |
| frame_end_i | input | 1 | Radio reports a frame finished |
| rx_on_o | output | 1 | Strobe: receiver on for the data frame |
| tx_start_o | output | 1 | Strobe: start data frame transmission |
| rx_giveup_o | output | 1 | Strobe: receive window expired |
| ack_rx_on_o | output | 1 | Strobe: receiver on for the acknowledgement |
| ack_tx_start_o | output | 1 | Strobe: start acknowledgement transmission |
| ack_ok_o | output | 1 | Flag: acknowledgement seen in time |
| no_frame_o | output | 1 | Flag: no data frame began in the window |
| ack_missing_o | output | 1 | Flag: acknowledgement deadline passed |
| overrun_o | output | 1 | Flag: slot ended with the sequence unfinished |

## Verification
Every strobe and flag is registered once. Each result therefore appears in the cycle that directly follows the clock edge sampling the qualifying tick or radio input. For an event k ticks after a reference edge, with a tick every P cycles aligned to the slot start, that edge lies at k·P cycles past the slot start for slot offsets. For turnaround offsets it lies at (floor(F/P)+k)·P, where F is the cycle of the frame end. The bench drives inputs and samples all nine outputs on the falling edge of every cycle, counting edges from the strobe. It compares each output against these computed edge numbers for tick periods of 1, 2 and 3 cycles, including radio events one cycle inside each window boundary.

// File: rtl/slot_timer_pkg.sv
package slot_timer_pkg;

  typedef enum logic [1:0] {
    ROLE_IDLE = 2'b00,
    ROLE_TX   = 2'b01,
    ROLE_RX   = 2'b10,
    ROLE_NONE = 2'b11
  } role_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TX_WAIT,
    S_TX_FRAME,
    S_ACK_PRE,
    S_ACK_LISTEN,
    S_RX_PRE,
    S_RX_WAIT,
    S_RX_FRAME,
    S_ACK_HOLD,
    S_DONE
  } seq_state_e;

  // True on the edge whose tick brings a count to the given offset.
  function automatic logic tick_reaches(input logic tick, input logic [31:0] cnt,
                                        input logic [31:0] offset);
    return tick && ((cnt + 32'd1) == offset);
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned MAX = 10000,
  localparam int unsigned W = $clog2(MAX + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (clr)                    cnt <= '0;
    else if (tick && cnt != W'(MAX)) cnt <= cnt + 1'b1;
  end

  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && $past(cnt) == W'(MAX) && $past(rst_n)) |-> cnt == W'(MAX) || $past(clr));

endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import slot_timer_pkg::*;
#(
  parameter int unsigned SLOT_US       = 10000,
  parameter int unsigned RX_ON_US      = 1020,
  parameter int unsigned TX_GO_US      = 2120,
  parameter int unsigned RX_WAIT_US    = 2200,
  parameter int unsigned ACK_TURN_US   = 1000,
  parameter int unsigned ACK_LISTEN_US = 800,
  parameter int unsigned ACK_LIMIT_US  = 1400,
  localparam int unsigned RX_LAST_US   = RX_ON_US + RX_WAIT_US
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        us_tick,
  input  logic        slot_start,
  input  logic [1:0]  role_i,
  input  logic        frame_detect_i,
  input  logic        frame_end_i,
  input  logic [31:0] slot_cnt,
  input  logic [31:0] turn_cnt,
  output logic        turn_clr,
  output logic        rx_on_o,
  output logic        tx_start_o,
  output logic        rx_giveup_o,
  output logic        ack_rx_on_o,
  output logic        ack_tx_start_o,
  output logic        ack_ok_o,
  output logic        no_frame_o,
  output logic        ack_missing_o,
  output logic        overrun_o
);

  seq_state_e st;

  // Named timing events, shared by the state machine and the assertions.
  logic ev_tx_go, ev_rx_on, ev_rx_last, ev_slot_end;
  logic ev_ack_listen, ev_ack_limit, ev_ack_turn;
  logic busy;
  logic [4:0] strobes;

  assign ev_tx_go      = tick_reaches(us_tick, slot_cnt, TX_GO_US);
  assign ev_rx_on      = tick_reaches(us_tick, slot_cnt, RX_ON_US);
  assign ev_rx_last    = tick_reaches(us_tick, slot_cnt, RX_LAST_US);
  assign ev_slot_end   = tick_reaches(us_tick, slot_cnt, SLOT_US);
  assign ev_ack_listen = tick_reaches(us_tick, turn_cnt, ACK_LISTEN_US);
  assign ev_ack_limit  = tick_reaches(us_tick, turn_cnt, ACK_LIMIT_US);
  assign ev_ack_turn   = tick_reaches(us_tick, turn_cnt, ACK_TURN_US);

  assign busy     = (st != S_IDLE) && (st != S_DONE);
  assign turn_clr = !slot_start && frame_end_i && (st == S_TX_FRAME || st == S_RX_FRAME);
  assign strobes  = {rx_on_o, tx_start_o, rx_giveup_o, ack_rx_on_o, ack_tx_start_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {rx_on_o, tx_start_o, rx_giveup_o, ack_rx_on_o, ack_tx_start_o} <= '0;
      {ack_ok_o, no_frame_o, ack_missing_o, overrun_o} <= '0;
    end else begin
      {rx_on_o, tx_start_o, rx_giveup_o, ack_rx_on_o, ack_tx_start_o} <= '0;
      if (slot_start) begin
        {ack_ok_o, no_frame_o, ack_missing_o, overrun_o} <= '0;
        case (role_e'(role_i))
          ROLE_TX: st <= S_TX_WAIT;
          ROLE_RX: st <= S_RX_PRE;
          default: st <= S_IDLE;
        endcase
      end else if (busy && ev_slot_end) begin
        overrun_o <= 1'b1;
        st        <= S_DONE;
      end else begin
        case (st)
          S_TX_WAIT: if (ev_tx_go) begin tx_start_o <= 1'b1; st <= S_TX_FRAME; end
          S_TX_FRAME: if (frame_end_i) st <= S_ACK_PRE;
          S_ACK_PRE: if (ev_ack_listen) begin ack_rx_on_o <= 1'b1; st <= S_ACK_LISTEN; end
          S_ACK_LISTEN: begin
            if (frame_detect_i) begin
              ack_ok_o <= 1'b1;
              st       <= S_DONE;
            end else if (ev_ack_limit) begin
              ack_missing_o <= 1'b1;
              st            <= S_DONE;
            end
          end
          S_RX_PRE: if (ev_rx_on) begin rx_on_o <= 1'b1; st <= S_RX_WAIT; end
          S_RX_WAIT: begin
            if (frame_detect_i) begin
              st <= S_RX_FRAME;
            end else if (ev_rx_last) begin
              rx_giveup_o <= 1'b1;
              no_frame_o  <= 1'b1;
              st          <= S_DONE;
            end
          end
          S_RX_FRAME: if (frame_end_i) st <= S_ACK_HOLD;
          S_ACK_HOLD: if (ev_ack_turn) begin ack_tx_start_o <= 1'b1; st <= S_DONE; end
          default: ;
        endcase
      end
    end
  end

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));
  p_strobe_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobes) |=> ((strobes & $past(strobes)) == '0));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (strobes == '0 && !ack_ok_o && !ack_missing_o));
  p_ack_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_ok_o && ack_missing_o));
  p_giveup_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_giveup_o |-> no_frame_o);
  p_tx_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_start_o) |-> $past(us_tick));
  p_clear_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !(ack_ok_o || no_frame_o || ack_missing_o || overrun_o));

endmodule

// File: rtl/slot_event_timer.sv
module slot_event_timer
  import slot_timer_pkg::*;
#(
  parameter int unsigned SLOT_US       = 10000,
  parameter int unsigned RX_ON_US      = 1020,
  parameter int unsigned TX_GO_US      = 2120,
  parameter int unsigned RX_WAIT_US    = 2200,
  parameter int unsigned ACK_TURN_US   = 1000,
  parameter int unsigned ACK_LISTEN_US = 800,
  parameter int unsigned ACK_LIMIT_US  = 1400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       slot_start,
  input  logic [1:0] role_i,
  input  logic       frame_detect_i,
  input  logic       frame_end_i,
  output logic       rx_on_o,
  output logic       tx_start_o,
  output logic       rx_giveup_o,
  output logic       ack_rx_on_o,
  output logic       ack_tx_start_o,
  output logic       ack_ok_o,
  output logic       no_frame_o,
  output logic       ack_missing_o,
  output logic       overrun_o
);

  localparam int unsigned TURN_MAX = max_of(ACK_TURN_US, ACK_LIMIT_US);
  localparam int unsigned SW = $clog2(SLOT_US + 1);
  localparam int unsigned TW = $clog2(TURN_MAX + 1);

  logic [SW-1:0] slot_cnt;
  logic [TW-1:0] turn_cnt;
  logic          turn_clr;

  tick_counter #(.MAX(SLOT_US)) u_slot_cnt (
    .clk(clk), .rst_n(rst_n), .clr(slot_start), .tick(us_tick), .cnt(slot_cnt)
  );

  tick_counter #(.MAX(TURN_MAX)) u_turn_cnt (
    .clk(clk), .rst_n(rst_n), .clr(turn_clr), .tick(us_tick), .cnt(turn_cnt)
  );

  slot_sequencer #(
    .SLOT_US(SLOT_US), .RX_ON_US(RX_ON_US), .TX_GO_US(TX_GO_US),
    .RX_WAIT_US(RX_WAIT_US), .ACK_TURN_US(ACK_TURN_US),
    .ACK_LISTEN_US(ACK_LISTEN_US), .ACK_LIMIT_US(ACK_LIMIT_US)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .slot_start(slot_start),
    .role_i(role_i), .frame_detect_i(frame_detect_i), .frame_end_i(frame_end_i),
    .slot_cnt(32'(slot_cnt)), .turn_cnt(32'(turn_cnt)), .turn_clr(turn_clr),
    .rx_on_o(rx_on_o), .tx_start_o(tx_start_o), .rx_giveup_o(rx_giveup_o),
    .ack_rx_on_o(ack_rx_on_o), .ack_tx_start_o(ack_tx_start_o),
    .ack_ok_o(ack_ok_o), .no_frame_o(no_frame_o),
    .ack_missing_o(ack_missing_o), .overrun_o(overrun_o)
  );

endmodule

// File: tb/tb_slot_event_timer.sv
`timescale 1ns/1ps
module tb_slot_event_timer;

  localparam int SL = 120, RXON = 10, TXG = 21, RW = 22, AD = 10, AON = 8, AW = 14;

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, slot_start = 1'b0;
  logic [1:0] role_i = 2'b00;
  logic frame_detect_i = 1'b0, frame_end_i = 1'b0;
  logic rx_on_o, tx_start_o, rx_giveup_o, ack_rx_on_o, ack_tx_start_o;
  logic ack_ok_o, no_frame_o, ack_missing_o, overrun_o;

  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  slot_event_timer #(
    .SLOT_US(SL), .RX_ON_US(RXON), .TX_GO_US(TXG), .RX_WAIT_US(RW),
    .ACK_TURN_US(AD), .ACK_LISTEN_US(AON), .ACK_LIMIT_US(AW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .slot_start(slot_start),
    .role_i(role_i), .frame_detect_i(frame_detect_i), .frame_end_i(frame_end_i),
    .rx_on_o(rx_on_o), .tx_start_o(tx_start_o), .rx_giveup_o(rx_giveup_o),
    .ack_rx_on_o(ack_rx_on_o), .ack_tx_start_o(ack_tx_start_o),
    .ack_ok_o(ack_ok_o), .no_frame_o(no_frame_o),
    .ack_missing_o(ack_missing_o), .overrun_o(overrun_o)
  );

  task automatic chk(input logic act, input logic exp, input string tag,
                     input string name, input int n);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at edge %0d: actual %b expected %b", tag, name, n, act, exp);
    end
  endtask

  function automatic logic at(input int n, input int e);
    return (e >= 0) && (n == e);
  endfunction

  function automatic logic since(input int n, input int e);
    return (e >= 0) && (n >= e);
  endfunction

  // One slot; d and f are the edge numbers (from the slot strobe) of a
  // detect pulse and an end pulse, -1 for none. Ticks land every p edges.
  task automatic run_slot(input int role, input int p, input int d, input int f);
    int st_end = SL * p;
    int e_tx = -1, e_on = -1, e_give = -1, e_aon = -1, e_miss = -1;
    int e_ok = -1, e_atx = -1, e_ovr = -1;
    bit idle = (role == 0 || role == 3);
    if (role == 1) begin
      e_tx = TXG * p;
      if (f > e_tx && f < st_end) begin
        e_aon = (f / p + AON) * p;
        if (d > e_aon && d < (f / p + AW) * p) e_ok = d;
        else e_miss = (f / p + AW) * p;
      end else e_ovr = st_end;
    end else if (role == 2) begin
      e_on = RXON * p;
      if (d > e_on && d < (RXON + RW) * p) begin
        if (f > d && f < st_end) e_atx = (f / p + AD) * p;
        else e_ovr = st_end;
      end else e_give = (RXON + RW) * p;
    end
    @(negedge clk);
    slot_start = 1'b1; role_i = 2'(role); us_tick = 1'b0;
    frame_detect_i = 1'b0; frame_end_i = 1'b0;
    @(posedge clk);
    for (int n = 1; n <= st_end + 6; n++) begin
      @(negedge clk);
      begin
        int m = n - 1;
        chk(rx_on_o,        at(m, e_on),    idle ? "R8" : "R2", "rx_on", m);
        chk(tx_start_o,     at(m, e_tx),    idle ? "R8" : "R3", "tx_start", m);
        chk(rx_giveup_o,    at(m, e_give),  idle ? "R8" : "R4", "rx_giveup", m);
        chk(no_frame_o,     since(m, e_give), idle ? "R8" : "R4", "no_frame", m);
        chk(ack_tx_start_o, at(m, e_atx),   idle ? "R8" : "R5", "ack_tx_start", m);
        chk(ack_rx_on_o,    at(m, e_aon),   idle ? "R8" : "R6", "ack_rx_on", m);
        chk(ack_ok_o,       since(m, e_ok),   idle ? "R8" : "R7", "ack_ok", m);
        chk(ack_missing_o,  since(m, e_miss), idle ? "R8" : "R7", "ack_missing", m);
        chk(overrun_o,      since(m, e_ovr),  idle ? "R8" : "R9", "overrun", m);
        chk($countones({rx_on_o, tx_start_o, rx_giveup_o, ack_rx_on_o, ack_tx_start_o}) <= 1,
            1'b1, "R10", "strobe_count", m);
      end
      slot_start = 1'b0;
      us_tick = (n % p == 0);
      frame_detect_i = (n == d);
      frame_end_i = (n == f);
      @(posedge clk);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(|{rx_on_o, tx_start_o, rx_giveup_o, ack_rx_on_o, ack_tx_start_o}, 1'b0, "R1", "strobes_in_reset", 0);
    chk(|{ack_ok_o, no_frame_o, ack_missing_o, overrun_o}, 1'b0, "R1", "flags_in_reset", 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(|{rx_on_o, tx_start_o, rx_giveup_o, ack_rx_on_o, ack_tx_start_o, ack_ok_o,
          no_frame_o, ack_missing_o, overrun_o}, 1'b0, "R1", "after_reset", 0);
    for (int p = 1; p <= 3; p++) begin
      int ftx = TXG * p + 7 * p + 1;
      int drx = RXON * p + 5;
      run_slot(0, p, 15, 30);                          // R8
      run_slot(3, p, 40, 50);                          // R8
      run_slot(1, p, (ftx / p + AON) * p + 3, ftx);    // R3 R6 R7 ack seen
      run_slot(1, p, -1, ftx);                         // R7 ack missing
      run_slot(1, p, ftx + 2, ftx);                    // R7 detect before listen ignored
      run_slot(1, p, -1, -1);                          // R9 no frame end
      run_slot(2, p, drx, drx + 30);                   // R2 R5
      run_slot(2, p, -1, -1);                          // R4 nothing arrives
      run_slot(2, p, RXON * p - 2, -1);                // R4 detect before rx_on ignored
      run_slot(2, p, drx, -1);                         // R9 frame never ends
      run_slot(2, p, (RXON + RW) * p - 1, (RXON + RW) * p + 3); // R4 last edge of window
    end
    run_slot(0, 1, -1, -1);                            // R9 flags cleared by next strobe
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule